// File: doc/BRIEF.md
# Serial flash target command decoder

This block is the device side of a single-lane SPI link. It behaves like the command front end of a serial NOR flash. A frame opens when chip select falls. The first byte is the command. Depending on that command, the block then collects a four-byte address and either shifts bytes back (status, identification or array data) or gathers a page of write data. The block contains a byte-wide storage array and a 256-entry page buffer. After chip select rises, a commit engine copies the buffered page into the array, or fills an erase block with FFh. It writes one byte per system clock and reports busy while it does so.

The block runs on a system clock `clk`. It oversamples the serial clock, chip select and MOSI through two-stage synchronisers, so the serial clock must stay at least four `clk` periods high and four `clk` periods low. The link uses SPI mode 0 and sends bytes most significant bit first.

Top module: `flash_cmd_target`

## Requirements
- R1: After reset the status byte reads 00h, every array byte reads FFh and `spi_miso` is low.
- R2: MOSI is sampled on the rising serial clock edge and MISO changes after the falling edge, MSB first. The command is the first 8 bits after chip select falls. `spi_miso` is low whenever chip select is high.
- R3: Command 05h returns the status byte repeatedly until chip select rises. Status bit 0 is busy, bit 1 is the write-enable latch, and bits 7..2 are zero.
- R4: Command 9Eh or 9Fh returns the ID_LEN identification bytes. Byte i equals (A5h + 37*i) mod 256, with ID_LEN = 20 by default. The sequence restarts from byte 0 until chip select rises.
- R5: Command 06h sets the write-enable latch and command 04h clears it.
- R6: Command 03h takes four address bytes (MSB first, only the low log2(MEM_BYTES) bits used). It then returns array bytes from consecutive addresses, wrapping at the array end, until chip select rises.
- R7: Command 02h with the latch set takes four address bytes, then data bytes. When chip select rises, the data is written in arrival order starting at the given address, with the address wrapping at the array end. If the frame carries no data byte, nothing is written.
- R8: If a write frame carries more than 256 data bytes, only the last 256 are stored, in arrival order, starting at the given address.
- R9: Commands 02h and D8h are ignored while the latch is clear: the array is unchanged and the latch stays clear.
- R10: Command D8h with the latch set and four address bytes sets to FFh the aligned ERASE_BYTES block (256 by default) that holds the address.
- R11: During a commit, busy is set and the array receives one byte per clock. The latch clears when the write or erase completes, and also at chip select rise for an accepted write that had no data.
- R12: While busy, every command except 05h is ignored for the rest of its frame.
- R13: An unrecognised command makes the block ignore the rest of the frame. Later bytes in that frame have no effect and `spi_miso` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_clk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing each command |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
The case that overlaps two functions is a status readout arriving while the commit engine is still writing a page. The bench starts a 300-byte write and, right after chip select rises, sends a write-disable frame and then a status frame while the commit is still in progress. The first status byte must show both busy and the latch set, which proves the disable was dropped. Further polling must then see both bits fall together, and a later readback must hold exactly the last 256 bytes sent.

// File: rtl/flash_cmd_pkg.sv
// Shared command codes and state encodings for the serial flash target.
package flash_cmd_pkg;
    localparam logic [7:0] OP_STATUS    = 8'h05;
    localparam logic [7:0] OP_RD        = 8'h03;
    localparam logic [7:0] OP_ID0       = 8'h9E;
    localparam logic [7:0] OP_ID1       = 8'h9F;
    localparam logic [7:0] OP_WEN_SET   = 8'h06;
    localparam logic [7:0] OP_WEN_CLR   = 8'h04;
    localparam logic [7:0] OP_PAGE_WR   = 8'h02;
    localparam logic [7:0] OP_BLK_ERASE = 8'hD8;

    typedef enum logic [2:0] {
        PH_OPCODE, PH_ADDR, PH_DATA_IN, PH_ARMED, PH_DATA_OUT, PH_IGNORE
    } phase_e;

    typedef enum logic [1:0] {SRC_STATUS, SRC_ID, SRC_MEM} src_e;

    typedef enum logic [1:0] {K_NONE, K_READ, K_PROG, K_ERASE} kind_e;
endpackage

// File: rtl/spi_edge_sync.sv
// Brings the host's serial clock, select and data into the clk domain and
// flags serial clock edges. Assumes each serial clock level lasts >= 4 clk.
module spi_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_clk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic clk_rise,
    output logic clk_fall,
    output logic cs_act,
    output logic cs_end,
    output logic mosi_s
);
    logic [2:0] sclk_sh;
    logic [2:0] cs_sh;
    logic [1:0] mosi_sh;

    // two-stage synchronisers plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sh <= 3'b000;
            cs_sh   <= 3'b111;
            mosi_sh <= 2'b00;
        end else begin
            sclk_sh <= {sclk_sh[1:0], spi_clk};
            cs_sh   <= {cs_sh[1:0], spi_cs_n};
            mosi_sh <= {mosi_sh[0], spi_mosi};
        end
    end

    // edge flags, serial edges only count inside a frame
    always_comb begin
        cs_act   = ~cs_sh[1];
        cs_end   = cs_sh[1] & ~cs_sh[2];
        clk_rise = cs_act & sclk_sh[1] & ~sclk_sh[2];
        clk_fall = cs_act & ~sclk_sh[1] & sclk_sh[2];
        mosi_s   = mosi_sh[1];
    end
endmodule

// File: rtl/flash_page_buffer.sv
// Byte buffer holding one page of write data; index wraps at DEPTH.
// Assumes DEPTH is a power of two. Contents are not reset.
module flash_page_buffer #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] store [DEPTH];

    // single write port
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // asynchronous read for the commit engine
    always_comb rdata = store[raddr];
endmodule

// File: rtl/flash_array.sv
// Byte-wide storage array, reset to the erased value FFh.
// Assumes DEPTH is a power of two and small enough to hold in flops.
module flash_array #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    // erased on reset, one byte written per clock otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // asynchronous read for the serial readout path
    always_comb rdata = cells[raddr];
endmodule

// File: rtl/flash_commit_engine.sv
// Copies a buffered page, or FFh for an erase, into the array one byte per
// clock. A program starts at base. An erase starts at base aligned down to
// ERASE_BYTES. Assumes start only arrives while idle and count >= 1.
module flash_commit_engine #(
    parameter int AW          = 10,
    parameter int PAGE_AW     = 8,
    parameter int CNT_W       = 9,
    parameter int ERASE_BYTES = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               is_erase,
    input  logic [AW-1:0]      base,
    input  logic [CNT_W-1:0]   count,
    input  logic [PAGE_AW-1:0] start_idx,
    input  logic [7:0]         buf_rdata,
    output logic [PAGE_AW-1:0] buf_raddr,
    output logic               busy,
    output logic               done,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [7:0]         mem_wdata
);
    localparam logic [AW-1:0] ERASE_MASK = AW'(ERASE_BYTES - 1);

    logic               erase_q;
    logic [AW-1:0]      base_q;
    logic [CNT_W-1:0]   total;
    logic [CNT_W-1:0]   k;
    logic [PAGE_AW-1:0] sidx;

    // run control: latch the job, step k until the last byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            erase_q <= 1'b0;
            base_q  <= '0;
            total   <= '0;
            k       <= '0;
            sidx    <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            erase_q <= is_erase;
            base_q  <= is_erase ? (base & ~ERASE_MASK) : base;
            total   <= is_erase ? CNT_W'(ERASE_BYTES) : count;
            sidx    <= is_erase ? '0 : start_idx;
            k       <= '0;
        end else if (busy) begin
            k <= k + 1'b1;
            if (done) busy <= 1'b0;
        end
    end

    // array and buffer addressing for the current step
    always_comb begin
        done      = busy && (k == total - 1'b1);
        mem_we    = busy;
        mem_addr  = base_q + AW'(k);
        mem_wdata = erase_q ? 8'hFF : buf_rdata;
        buf_raddr = sidx + PAGE_AW'(k);
    end
endmodule

// File: rtl/flash_cmd_target.sv
// Device-side command decoder of a serial NOR flash on a mode-0 SPI link.
// Decodes the command byte, gathers a 4-byte address, streams status, ID or
// array data, and buffers page writes for commit after chip select rises.
// Assumes the serial clock levels last >= 4 clk each.
module flash_cmd_target #(
    parameter int         MEM_BYTES   = 1024,
    parameter int         PAGE_BYTES  = 256,
    parameter int         ERASE_BYTES = 256,
    parameter int         ID_LEN      = 20,
    parameter logic [7:0] ID_SEED     = 8'hA5,
    parameter logic [7:0] ID_STEP     = 8'd37
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_clk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    import flash_cmd_pkg::*;

    localparam int MEM_AW  = $clog2(MEM_BYTES);
    localparam int PAGE_AW = $clog2(PAGE_BYTES);
    localparam int CNT_W   = $clog2((PAGE_BYTES > ERASE_BYTES ? PAGE_BYTES : ERASE_BYTES) + 1);
    localparam int ID_W    = (ID_LEN > 1) ? $clog2(ID_LEN) : 1;
    localparam logic [ID_W-1:0]  ID_LAST  = ID_W'(ID_LEN - 1);
    localparam logic [CNT_W-1:0] PAGE_CAP = CNT_W'(PAGE_BYTES);

    logic clk_rise, clk_fall, cs_act, cs_end, mosi_s;

    phase_e             phase;
    kind_e              kind;
    src_e               src;
    logic [2:0]         bit_cnt;
    logic [6:0]         rx_sh;
    logic [6:0]         tx_sh;
    logic [MEM_AW-1:0]  addr_sh;
    logic [1:0]         addr_cnt;
    logic [MEM_AW-1:0]  rd_addr;
    logic [ID_W-1:0]    id_idx;
    logic [PAGE_AW-1:0] widx;
    logic [CNT_W-1:0]   wcount;
    logic               wel;
    logic               cmt_start;
    logic               cmt_erase;

    logic [7:0]         rx_byte;
    logic               byte_done;
    logic [MEM_AW-1:0]  addr_next;
    logic [7:0]         next_byte;
    logic [7:0]         id_byte;
    logic               buf_we;
    logic [PAGE_AW-1:0] cmt_sidx;

    logic               busy, cmt_done, mem_we;
    logic [MEM_AW-1:0]  mem_waddr;
    logic [7:0]         mem_wdata, mem_rdata, buf_rdata;
    logic [PAGE_AW-1:0] buf_raddr;

    spi_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_clk  (spi_clk),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .clk_rise (clk_rise),
        .clk_fall (clk_fall),
        .cs_act   (cs_act),
        .cs_end   (cs_end),
        .mosi_s   (mosi_s)
    );

    flash_page_buffer #(.DEPTH(PAGE_BYTES)) u_page (
        .clk   (clk),
        .we    (buf_we),
        .waddr (widx),
        .wdata (rx_byte),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    flash_array #(.DEPTH(MEM_BYTES)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (mem_rdata)
    );

    flash_commit_engine #(
        .AW(MEM_AW), .PAGE_AW(PAGE_AW), .CNT_W(CNT_W), .ERASE_BYTES(ERASE_BYTES)
    ) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmt_start),
        .is_erase  (cmt_erase),
        .base      (addr_sh),
        .count     (wcount),
        .start_idx (cmt_sidx),
        .buf_rdata (buf_rdata),
        .buf_raddr (buf_raddr),
        .busy      (busy),
        .done      (cmt_done),
        .mem_we    (mem_we),
        .mem_addr  (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    // byte assembly, buffer strobe and outgoing byte selection
    always_comb begin
        rx_byte   = {rx_sh, mosi_s};
        byte_done = cs_act && clk_rise && (bit_cnt == 3'd7);
        buf_we    = byte_done && (phase == PH_DATA_IN);
        addr_next = MEM_AW'({addr_sh, rx_byte});
        id_byte   = ID_SEED + ID_STEP * 8'(id_idx);
        cmt_sidx  = (wcount == PAGE_CAP) ? widx : '0;
        unique case (src)
            SRC_ID:  next_byte = id_byte;
            SRC_MEM: next_byte = mem_rdata;
            default: next_byte = {6'b0, wel, busy};
        endcase
    end

    // frame sequencing, command decode, latch and serial output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_OPCODE;
            kind      <= K_NONE;
            src       <= SRC_STATUS;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            spi_miso  <= 1'b0;
            addr_sh   <= '0;
            addr_cnt  <= '0;
            rd_addr   <= '0;
            id_idx    <= '0;
            widx      <= '0;
            wcount    <= '0;
            wel       <= 1'b0;
            cmt_start <= 1'b0;
            cmt_erase <= 1'b0;
        end else begin
            cmt_start <= 1'b0;
            if (cmt_done) wel <= 1'b0;
            if (!cs_act) begin
                phase    <= PH_OPCODE;
                kind     <= K_NONE;
                bit_cnt  <= '0;
                spi_miso <= 1'b0;
                if (cs_end) begin
                    if (kind == K_PROG) begin
                        if (phase == PH_DATA_IN && wcount != '0) begin
                            cmt_start <= 1'b1;
                            cmt_erase <= 1'b0;
                        end else begin
                            wel <= 1'b0;
                        end
                    end else if (kind == K_ERASE) begin
                        if (phase == PH_ARMED) begin
                            cmt_start <= 1'b1;
                            cmt_erase <= 1'b1;
                        end else begin
                            wel <= 1'b0;
                        end
                    end
                end
            end else begin
                if (clk_rise) begin
                    rx_sh   <= rx_byte[6:0];
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (byte_done) begin
                    case (phase)
                        PH_OPCODE: begin
                            if (busy && rx_byte != OP_STATUS) begin
                                phase <= PH_IGNORE;
                            end else begin
                                case (rx_byte)
                                    OP_STATUS: begin
                                        phase <= PH_DATA_OUT;
                                        src   <= SRC_STATUS;
                                    end
                                    OP_ID0, OP_ID1: begin
                                        phase  <= PH_DATA_OUT;
                                        src    <= SRC_ID;
                                        id_idx <= '0;
                                    end
                                    OP_RD: begin
                                        phase    <= PH_ADDR;
                                        kind     <= K_READ;
                                        addr_cnt <= '0;
                                    end
                                    OP_WEN_SET: begin
                                        wel   <= 1'b1;
                                        phase <= PH_IGNORE;
                                    end
                                    OP_WEN_CLR: begin
                                        wel   <= 1'b0;
                                        phase <= PH_IGNORE;
                                    end
                                    OP_PAGE_WR, OP_BLK_ERASE: begin
                                        if (wel) begin
                                            phase    <= PH_ADDR;
                                            kind     <= (rx_byte == OP_PAGE_WR) ? K_PROG : K_ERASE;
                                            addr_cnt <= '0;
                                        end else begin
                                            phase <= PH_IGNORE;
                                        end
                                    end
                                    default: phase <= PH_IGNORE;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            addr_sh  <= addr_next;
                            addr_cnt <= addr_cnt + 2'd1;
                            if (addr_cnt == 2'd3) begin
                                case (kind)
                                    K_READ: begin
                                        phase   <= PH_DATA_OUT;
                                        src     <= SRC_MEM;
                                        rd_addr <= addr_next;
                                    end
                                    K_PROG: begin
                                        phase  <= PH_DATA_IN;
                                        wcount <= '0;
                                        widx   <= '0;
                                    end
                                    default: phase <= PH_ARMED;
                                endcase
                            end
                        end
                        PH_DATA_IN: begin
                            widx <= widx + 1'b1;
                            if (wcount != PAGE_CAP) wcount <= wcount + 1'b1;
                        end
                        default: ;
                    endcase
                end
                if (clk_fall && phase == PH_DATA_OUT) begin
                    if (bit_cnt == 3'd0) begin
                        spi_miso <= next_byte[7];
                        tx_sh    <= next_byte[6:0];
                        if (src == SRC_MEM) rd_addr <= rd_addr + 1'b1;
                        if (src == SRC_ID) id_idx <= (id_idx == ID_LAST) ? '0 : id_idx + 1'b1;
                    end else begin
                        spi_miso <= tx_sh[6];
                        tx_sh    <= {tx_sh[5:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/flash_cmd_checker.sv
// Temporal checks on the flash target; bound to every flash_cmd_target.
module flash_cmd_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic wel,
    input logic mem_we,
    input logic cs_act,
    input logic spi_miso,
    input logic buf_we
);
    AST_WRITE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R11
    AST_BUSY_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wel); // R11
    AST_LATCH_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel); // R11
    AST_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel); // R9
    AST_MISO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_miso); // R2
    AST_NO_CAPTURE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we); // R12
endmodule

bind flash_cmd_target flash_cmd_checker u_flash_cmd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .wel      (wel),
    .mem_we   (mem_we),
    .cs_act   (cs_act),
    .spi_miso (spi_miso),
    .buf_we   (buf_we)
);

// File: tb/test_flash_cmd_target.sv
// Bench for flash_cmd_target: directed corners plus seeded random traffic
// checked against a byte-level model of the array and latch.
module test_flash_cmd_target;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int MEM        = 1024;
    localparam int ID_LEN     = 20;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    bit  model_wel = 0;
    logic [7:0] model_mem [MEM];
    logic [7:0] wbuf [512];

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_cmd_target i_flash_cmd_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_clk  (sclk),
        .spi_cs_n (cs_n),
        .spi_mosi (mosi),
        .spi_miso (miso)
    );

    function automatic logic [7:0] exp_id(int i);
        return 8'(8'hA5 + 37 * i);
    endfunction

    function automatic logic [7:0] exp_status(bit b, bit w);
        return {6'b0, w, b};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_close();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic send_addr(input logic [31:0] a);
        logic [7:0] rx;
        for (int i = 3; i >= 0; i--) xfer(a[8*i +: 8], rx);
    endtask

    task automatic single_cmd(input logic [7:0] op);
        logic [7:0] rx;
        frame_open();
        xfer(op, rx);
        frame_close();
        if (op == 8'h06) model_wel = 1;
        if (op == 8'h04) model_wel = 0;
    endtask

    task automatic read_status(output logic [7:0] st);
        logic [7:0] rx;
        frame_open();
        xfer(8'h05, rx);
        xfer(8'h00, st);
        frame_close();
    endtask

    task automatic wait_idle(string req);
        logic [7:0] st;
        int n = 0;
        read_status(st);
        while (st[0] && n < 50) begin
            read_status(st);
            n++;
        end
        check(req, st, exp_status(0, model_wel));
    endtask

    task automatic page_write(input logic [31:0] a, input int len);
        logic [7:0] rx;
        frame_open();
        xfer(8'h02, rx);
        send_addr(a);
        for (int k = 0; k < len; k++) xfer(wbuf[k], rx);
        frame_close();
        if (model_wel) begin
            if (len > 0) begin
                int n = (len > 256) ? 256 : len;
                for (int k = 0; k < n; k++)
                    model_mem[(a + k) & (MEM - 1)] = wbuf[len - n + k];
            end
            model_wel = 0;
        end
    endtask

    task automatic block_erase(input logic [31:0] a);
        logic [7:0] rx;
        frame_open();
        xfer(8'hD8, rx);
        send_addr(a);
        frame_close();
        if (model_wel) begin
            int base = a & (MEM - 1) & ~255;
            for (int k = 0; k < 256; k++) model_mem[base + k] = 8'hFF;
            model_wel = 0;
        end
    endtask

    task automatic read_check(input logic [31:0] a, input int len, string req);
        logic [7:0] rx;
        frame_open();
        xfer(8'h03, rx);
        send_addr(a);
        for (int k = 0; k < len; k++) begin
            xfer(8'h00, rx);
            check(req, rx, model_mem[(a + k) & (MEM - 1)]);
        end
        frame_close();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all R): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] st, rx;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM; i++) model_mem[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        check("R1 miso low after reset", miso, 1'b0);
        read_status(st);
        check("R1 status after reset", st, 8'h00);
        read_check(32'h0, 8, "R1 R6 erased array after reset");

        // R4 identification, repeating after ID_LEN
        frame_open();
        xfer(8'h9F, rx);
        for (int i = 0; i < 2 * ID_LEN + 3; i++) begin
            xfer(8'h00, rx);
            check("R4 id byte (9F)", rx, exp_id(i % ID_LEN));
        end
        frame_close();
        frame_open();
        xfer(8'h9E, rx);
        for (int i = 0; i < 4; i++) begin
            xfer(8'h00, rx);
            check("R4 id byte (9E)", rx, exp_id(i));
        end
        frame_close();

        // R5 and R3: latch set, status repeats; then cleared
        single_cmd(8'h06);
        frame_open();
        xfer(8'h05, rx);
        check("R2 miso low during command byte", rx, 8'h00);
        for (int i = 0; i < 5; i++) begin
            xfer(8'h00, rx);
            check("R3 R5 repeated status with latch", rx, 8'h02);
        end
        frame_close();
        single_cmd(8'h04);
        read_status(st);
        check("R5 latch cleared", st, 8'h00);

        // R9 write and erase without latch
        for (int k = 0; k < 4; k++) wbuf[k] = 8'(k + 8'h30);
        page_write(32'h10, 4);
        block_erase(32'h10);
        read_status(st);
        check("R9 latch stays clear", st, 8'h00);
        read_check(32'h10, 4, "R9 array untouched");

        // R7 write wrapping at array end, R6 read wrapping
        single_cmd(8'h06);
        for (int k = 0; k < 5; k++) wbuf[k] = 8'($urandom);
        page_write(32'hABCD_03FE, 5);
        wait_idle("R11 idle and latch clear after write");
        read_check(32'h0000_03FE, 5, "R7 R6 wrapped write readback");

        // R7 R11 accepted write with no data
        single_cmd(8'h06);
        page_write(32'h40, 0);
        read_status(st);
        check("R11 latch clear after empty write", st, 8'h00);
        read_check(32'h40, 2, "R7 empty write stores nothing");

        // R8 R12 R11: overflow write, disable during commit, status during commit
        single_cmd(8'h06);
        for (int k = 0; k < 300; k++) wbuf[k] = 8'($urandom);
        page_write(32'h100, 300);
        frame_open();
        xfer(8'h04, rx);
        frame_close();
        read_status(st);
        check("R12 R11 busy with latch kept during commit", st, 8'h03);
        wait_idle("R11 commit ends with latch clear");
        read_check(32'h0FF, 258, "R8 last 256 bytes kept in order");

        // R10 block erase
        single_cmd(8'h06);
        block_erase(32'h0000_0150);
        wait_idle("R10 R11 erase completes");
        read_check(32'h0F8, 272, "R10 block erased, neighbours kept");

        // R13 unrecognised command poisons the frame
        frame_open();
        xfer(8'hAB, rx);
        for (int i = 0; i < 3; i++) begin
            xfer(8'h06, rx);
            check("R13 miso quiet after unknown command", rx, 8'h00);
        end
        frame_close();
        read_status(st);
        check("R13 later bytes had no effect", st, 8'h00);

        // random traffic
        for (int n = 0; n < 12; n++) begin
            int op = $urandom % 3;
            logic [31:0] a = $urandom;
            if (op == 0) begin
                int len = 1 + ($urandom % 32);
                if ($urandom % 4 != 0) single_cmd(8'h06);
                for (int k = 0; k < len; k++) wbuf[k] = 8'($urandom);
                page_write(a, len);
                wait_idle("R7 R9 random write settles");
                read_check(a, len, "R7 R9 random write readback");
            end else if (op == 1) begin
                if ($urandom % 2 != 0) single_cmd(8'h06);
                block_erase(a);
                wait_idle("R10 R9 random erase settles");
                read_check(a - 2, 6, "R10 R9 random erase readback");
            end else begin
                read_check(a, 16, "R6 random read");
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule